// File: doc/BRIEF.md
# Four-Channel Interval Timer with Selectable Modes

The block holds a set of independent down-counting timers behind one flat register port. Software gives a channel an interval length, which starts it at once. The channel then counts one step per clock until its interval has run out. What it does at that point depends on a two-bit mode field in its control register. In repeat mode it reloads and keeps going. In one-shot mode it halts. In both of these modes it raises a pending flag.

The third mode also halts at the end of the interval, but it leaves the pending flag alone. Instead it sends a one-cycle completion strobe, which lets outside logic release a transaction that it has been holding back.

Each channel's pending flag, gated by that channel's interrupt enable, drives a per-channel interrupt line. The OR of these lines drives a global interrupt. Pending and in-use flags are cleared by writing a one to them. The status word also carries a running indicator that software cannot write.

Top module: `ivt_timer`

## Requirements
- R1: After reset, every register of every channel reads 0, and `irq_ch`, `irq_any` and `stall_done` are all 0.
- R2: The word address is {channel, register}, with the register code in the low two bits: 0 is interval, 1 is current count (read-only), 2 is control and 3 is status. Control bit 0 is the interrupt enable. Control bits 2:1 are the mode: 0 repeat, 1 one-shot, 2 stall, 3 reserved. Status bit 0 is pending, bit 1 is running and bit 2 is in-use. `rsp_rdata` follows `req_addr` combinationally, and unused bits read 0.
- R3: Writing a nonzero value V to the interval register does three things: the count becomes V, running is set and in-use is set. The count then drops by one per clock, and the terminal event happens on the V-th rising edge after the write edge.
- R4: Writing zero to the interval register clears running and the count, and no terminal event follows.
- R5: In repeat mode, a terminal event reloads the count with the last interval, keeps running at 1 and sets pending.
- R6: In one-shot mode, a terminal event clears running and the count and sets pending.
- R7: In stall mode, a terminal event clears running and does not set pending. `stall_done` for that channel is high for exactly the one cycle after the terminal edge.
- R8: A status write with bit 0 set clears pending, and a write with bit 0 at 0 leaves it unchanged. If a terminal event falls on the same edge as the clear, pending ends up set.
- R9: `irq_ch[n]` is high exactly while channel n has both pending and enable at 1, and `irq_any` is the OR of all `irq_ch` bits.
- R10: A status write with bit 2 set clears in-use. Status bit 1 ignores writes.
- R11: A control write whose mode field is 3 leaves the mode unchanged but still updates the enable bit.
- R12: A channel's registers and outputs are unaffected by activity on any other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | Access is a write when 1 |
| req_addr | input | ADDR_W (4) | Word address {channel, register} |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_rdata | output | DATA_W (32) | Read data for `req_addr` |
| irq_ch | output | NUM_CH (4) | Per-channel interrupt lines |
| irq_any | output | 1 | Global interrupt |
| stall_done | output | NUM_CH (4) | Per-channel stall-mode completion strobe |

## Verification
The bench builds the block with its defaults: four channels, a 24-bit count and a 32-bit data word. With these values every channel address and both channel-select bits are exercised. Intervals of one to ten cycles bring terminal events, reloads and strobes into view within a few clocks. An interval of 1 puts the terminal edge directly after the start write. That case and a clear that lands on a terminal edge are the two timing corners the bench lines up cycle by cycle.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  typedef enum logic [1:0] {
    MD_REPEAT  = 2'd0,
    MD_ONESHOT = 2'd1,
    MD_STALL   = 2'd2,
    MD_RSVD    = 2'd3
  } ivt_mode_e;

  localparam int REG_SEL_W = 2;
  localparam logic [REG_SEL_W-1:0] REG_INTV  = 2'd0;
  localparam logic [REG_SEL_W-1:0] REG_COUNT = 2'd1;
  localparam logic [REG_SEL_W-1:0] REG_CTRL  = 2'd2;
  localparam logic [REG_SEL_W-1:0] REG_STAT  = 2'd3;

  localparam int FIELD_W = 3;

  // Terminal event raises the pending flag in every mode but stall
  function automatic logic mode_flags(ivt_mode_e m);
    return m != MD_STALL;
  endfunction

  // Only repeat mode keeps running past the terminal event
  function automatic logic mode_reloads(ivt_mode_e m);
    return m == MD_REPEAT;
  endfunction

endpackage

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_intv,
  input  logic               wr_ctrl,
  input  logic               wr_stat,
  input  logic [CNT_W-1:0]   wdata,
  output logic [CNT_W-1:0]   rd_intv,
  output logic [CNT_W-1:0]   rd_count,
  output logic [FIELD_W-1:0] rd_ctrl,
  output logic [FIELD_W-1:0] rd_stat,
  output logic               irq,
  output logic               stall_done
);

  function automatic logic at_terminal(logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] next_count(logic [CNT_W-1:0] c,
                                                  logic [CNT_W-1:0] r,
                                                  logic reload_en);
    if (at_terminal(c)) return reload_en ? r : '0;
    return c - 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q, reload_q;
  logic             run_q, pend_q, inuse_q, inten_q, done_q;
  ivt_mode_e        mode_q;

  // Named internal events
  logic start_req, stop_req, tc_evt, pend_set, pend_clr, inuse_clr, mode_ok;
  assign start_req = wr_intv && (wdata != '0);
  assign stop_req  = wr_intv && (wdata == '0);
  assign tc_evt    = run_q && at_terminal(cnt_q) && !wr_intv;
  assign pend_set  = tc_evt && mode_flags(mode_q);
  assign pend_clr  = wr_stat && wdata[0];
  assign inuse_clr = wr_stat && wdata[2];
  assign mode_ok   = wr_ctrl && (wdata[2:1] != MD_RSVD);

  // Counter and run state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
      run_q    <= 1'b0;
    end else if (wr_intv) begin
      cnt_q    <= wdata;
      reload_q <= wdata;
      run_q    <= start_req;
    end else if (run_q) begin
      cnt_q <= next_count(cnt_q, reload_q, mode_reloads(mode_q));
      if (tc_evt && !mode_reloads(mode_q)) run_q <= 1'b0;
    end
  end

  // Flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      inuse_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (pend_set)      pend_q <= 1'b1;
      else if (pend_clr) pend_q <= 1'b0;
      if (start_req)      inuse_q <= 1'b1;
      else if (inuse_clr) inuse_q <= 1'b0;
      done_q <= tc_evt && (mode_q == MD_STALL);
    end
  end

  // Control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inten_q <= 1'b0;
      mode_q  <= MD_REPEAT;
    end else begin
      if (wr_ctrl) inten_q <= wdata[0];
      if (mode_ok) mode_q  <= ivt_mode_e'(wdata[2:1]);
    end
  end

  assign rd_intv    = reload_q;
  assign rd_count   = cnt_q;
  assign rd_ctrl    = {mode_q, inten_q};
  assign rd_stat    = {inuse_q, run_q, pend_q};
  assign irq        = pend_q && inten_q;
  assign stall_done = done_q;

  AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> !run_q && !pend_set); // R4
  AST_REPEAT_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt && mode_q == MD_REPEAT |=> run_q && cnt_q == $past(reload_q)); // R5
  AST_ONESHOT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt && mode_q == MD_ONESHOT |=> !run_q && pend_q); // R6
  AST_STALL_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt && mode_q == MD_STALL && !pend_q |=> !pend_q && stall_done && !run_q); // R7
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr && !tc_evt |=> !pend_q); // R8
  AST_CLEAR_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    pend_clr && pend_set |=> pend_q); // R8
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !inten_q |-> !irq); // R9
  AST_RSVD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl && wdata[2:1] == 2'b11 |=> $stable(mode_q)); // R11

endmodule

// File: rtl/ivt_regdec.sv
module ivt_regdec
  import ivt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                           req_valid,
  input  logic                           req_write,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   intv_rd,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   count_rd,
  input  logic [NUM_CH-1:0][FIELD_W-1:0] ctrl_rd,
  input  logic [NUM_CH-1:0][FIELD_W-1:0] stat_rd,
  output logic [NUM_CH-1:0]              wr_intv,
  output logic [NUM_CH-1:0]              wr_ctrl,
  output logic [NUM_CH-1:0]              wr_stat,
  output logic [DATA_W-1:0]              rsp_rdata
);

  localparam int CH_W = ADDR_W - REG_SEL_W;

  logic [CH_W-1:0]      ch_sel;
  logic [REG_SEL_W-1:0] reg_sel;
  logic                 we;

  assign ch_sel  = req_addr[ADDR_W-1:REG_SEL_W];
  assign reg_sel = req_addr[REG_SEL_W-1:0];
  assign we      = req_valid && req_write;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    logic hit;
    assign hit        = we && (ch_sel == CH_W'(g));
    assign wr_intv[g] = hit && (reg_sel == REG_INTV);
    assign wr_ctrl[g] = hit && (reg_sel == REG_CTRL);
    assign wr_stat[g] = hit && (reg_sel == REG_STAT);
  end

  always_comb begin
    rsp_rdata = '0;
    if (int'(ch_sel) < NUM_CH) begin
      unique case (reg_sel)
        REG_INTV:  rsp_rdata = DATA_W'(intv_rd[ch_sel]);
        REG_COUNT: rsp_rdata = DATA_W'(count_rd[ch_sel]);
        REG_CTRL:  rsp_rdata = DATA_W'(ctrl_rd[ch_sel]);
        REG_STAT:  rsp_rdata = DATA_W'(stat_rd[ch_sel]);
        default:   rsp_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + REG_SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [NUM_CH-1:0] irq_ch,
  output logic              irq_any,
  output logic [NUM_CH-1:0] stall_done
);

  logic [NUM_CH-1:0][CNT_W-1:0]   intv_rd, count_rd;
  logic [NUM_CH-1:0][FIELD_W-1:0] ctrl_rd, stat_rd;
  logic [NUM_CH-1:0]              wr_intv, wr_ctrl, wr_stat;
  logic [DATA_W-CNT_W-1:0]        wdata_unused;

  assign wdata_unused = req_wdata[DATA_W-1:CNT_W];

  ivt_regdec #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .intv_rd   (intv_rd),
    .count_rd  (count_rd),
    .ctrl_rd   (ctrl_rd),
    .stat_rd   (stat_rd),
    .wr_intv   (wr_intv),
    .wr_ctrl   (wr_ctrl),
    .wr_stat   (wr_stat),
    .rsp_rdata (rsp_rdata)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ivt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_intv    (wr_intv[g]),
      .wr_ctrl    (wr_ctrl[g]),
      .wr_stat    (wr_stat[g]),
      .wdata      (req_wdata[CNT_W-1:0]),
      .rd_intv    (intv_rd[g]),
      .rd_count   (count_rd[g]),
      .rd_ctrl    (ctrl_rd[g]),
      .rd_stat    (stat_rd[g]),
      .irq        (irq_ch[g]),
      .stall_done (stall_done[g])
    );
  end

  assign irq_any = |irq_ch;

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_intv | wr_ctrl | wr_stat)); // R12
  AST_GLOBAL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> $countones(irq_ch) > 0); // R9

endmodule

// File: tb/tb_ivt_timer.sv
`timescale 1ns/100ps
module tb_ivt_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;
  logic [3:0]  irq_ch;
  logic        irq_any;
  logic [3:0]  stall_done;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ivt_timer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .irq_ch(irq_ch), .irq_any(irq_any), .stall_done(stall_done)
  );

  // {ch[13:12], mode[11:10], interval[9:2], exp_pend[1], exp_run[0]}
  localparam logic [13:0] VEC [6] = '{
    {2'd0, 2'd1, 8'd5, 1'b1, 1'b0},
    {2'd1, 2'd0, 8'd3, 1'b1, 1'b1},
    {2'd2, 2'd2, 8'd4, 1'b0, 1'b0},
    {2'd3, 2'd1, 8'd1, 1'b1, 1'b0},
    {2'd0, 2'd0, 8'd1, 1'b1, 1'b1},
    {2'd1, 2'd2, 8'd2, 1'b0, 1'b0}
  };

  function automatic logic [3:0] ad(input int ch, input int rg);
    return 4'(ch * 4 + rg);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    req_addr = a;
    #0.2;
    d = rsp_rdata;
  endtask

  task automatic stop_clear(input int ch);
    wr(ad(ch, 0), 32'd0);
    wr(ad(ch, 3), 32'h5);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int c = 0; c < 4; c++) begin
      for (int r = 0; r < 4; r++) begin
        rd(ad(c, r), d);
        chk("R1 reg reset", d, 32'd0);
      end
      @(negedge clk);
    end
    chk("R1 irq reset", {27'd0, stall_done, irq_any}, 32'd0);
    chk("R1 irq_ch reset", {28'd0, irq_ch}, 32'd0);

    // Table: R2 R3 R5 R6 R7 R9
    for (int i = 0; i < 6; i++) begin
      int ch, md, iv;
      logic ep, er;
      ch = int'(VEC[i][13:12]); md = int'(VEC[i][11:10]);
      iv = int'(VEC[i][9:2]); ep = VEC[i][1]; er = VEC[i][0];
      wr(ad(ch, 2), 32'(md * 2 + 1));
      rd(ad(ch, 2), d);
      chk("R2 ctrl readback", d, 32'(md * 2 + 1));
      wr(ad(ch, 1), 32'h5);
      wr(ad(ch, 0), 32'(iv));
      repeat (iv - 1) @(negedge clk);
      rd(ad(ch, 3), d);
      chk("R3 running before terminal", d, 32'h6);
      @(negedge clk);
      rd(ad(ch, 3), d);
      chk("R5 R6 R7 status after terminal", d, {29'd0, 1'b1, er, ep});
      rd(ad(ch, 1), d);
      chk("R5 R6 count after terminal", d, er ? 32'(iv) : 32'd0);
      chk("R7 stall strobe", {31'd0, stall_done[ch]}, {31'd0, md == 2});
      chk("R9 irq lines", {30'd0, irq_ch[ch], irq_any}, {30'd0, ep, ep});
      stop_clear(ch);
    end

    // R7 strobe lasts one cycle
    wr(ad(2, 2), 32'h4);
    wr(ad(2, 0), 32'd2);
    @(negedge clk); @(negedge clk);
    chk("R7 strobe high", {31'd0, stall_done[2]}, 32'd1);
    @(negedge clk);
    chk("R7 strobe one cycle", {31'd0, stall_done[2]}, 32'd0);
    stop_clear(2);

    // R8 write-one-to-clear
    wr(ad(0, 2), 32'h3);
    wr(ad(0, 0), 32'd3);
    repeat (3) @(negedge clk);
    wr(ad(0, 3), 32'h0);
    rd(ad(0, 3), d);
    chk("R8 zero write no effect", d, 32'h5);
    wr(ad(0, 3), 32'h1);
    rd(ad(0, 3), d);
    chk("R8 clear pending keeps inuse", d, 32'h4);
    wr(ad(0, 3), 32'h4);
    rd(ad(0, 3), d);
    chk("R10 inuse cleared", d, 32'h0);

    // R10 running bit not writable
    wr(ad(1, 2), 32'h0);
    wr(ad(1, 0), 32'd50);
    wr(ad(1, 3), 32'h2);
    rd(ad(1, 3), d);
    chk("R10 run ignores write", d, 32'h6);
    stop_clear(1);

    // R9 masked interrupt
    wr(ad(2, 2), 32'h2);
    wr(ad(2, 0), 32'd2);
    repeat (3) @(negedge clk);
    rd(ad(2, 3), d);
    chk("R9 pending while masked", d, 32'h5);
    chk("R9 masked lines low", {30'd0, irq_ch[2], irq_any}, 32'd0);
    stop_clear(2);

    // R11 reserved mode
    wr(ad(3, 2), 32'h5);
    wr(ad(3, 2), 32'h7);
    rd(ad(3, 2), d);
    chk("R11 reserved keeps mode", d, 32'h5);
    wr(ad(3, 2), 32'h6);
    rd(ad(3, 2), d);
    chk("R11 enable still written", d, 32'h4);

    // R4 zero stops
    wr(ad(3, 2), 32'h3);
    wr(ad(3, 0), 32'd10);
    repeat (3) @(negedge clk);
    wr(ad(3, 0), 32'd0);
    rd(ad(3, 1), d);
    chk("R4 count cleared", d, 32'd0);
    repeat (15) @(negedge clk);
    rd(ad(3, 3), d);
    chk("R4 stopped no pending", d, 32'h4);
    wr(ad(3, 3), 32'h4);

    // R3 count descends
    wr(ad(0, 2), 32'h3);
    wr(ad(0, 0), 32'd7);
    repeat (2) @(negedge clk);
    rd(ad(0, 1), d);
    chk("R3 count after two edges", d, 32'd5);
    rd(ad(0, 0), d);
    chk("R2 interval readback", d, 32'd7);
    stop_clear(0);

    // R8 terminal event wins over same-edge clear, R5 second period
    wr(ad(0, 2), 32'h1);
    wr(ad(0, 0), 32'd4);
    repeat (2) @(negedge clk);
    wr(ad(0, 3), 32'h1);
    rd(ad(0, 3), d);
    chk("R8 set wins over clear", d, 32'h7);
    wr(ad(0, 3), 32'h1);
    rd(ad(0, 3), d);
    chk("R5 cleared between periods", d, 32'h6);
    repeat (3) @(negedge clk);
    rd(ad(0, 3), d);
    chk("R5 pending again next period", d, 32'h7);
    stop_clear(0);

    // R12 independence
    wr(ad(1, 2), 32'h3);
    wr(ad(2, 2), 32'h3);
    wr(ad(1, 0), 32'd20);
    wr(ad(2, 0), 32'd3);
    repeat (3) @(negedge clk);
    rd(ad(2, 3), d);
    chk("R12 ch2 done", d, 32'h5);
    rd(ad(1, 3), d);
    chk("R12 ch1 unaffected", d, 32'h6);
    chk("R12 only ch2 irq", {28'd0, irq_ch}, 32'h4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule